// File: doc/BRIEF.md
# Disk Command Sequencer

This block drives one DMA read or write toward a storage device at the level of frame information structures. A request is a direction, a 48-bit logical block address and a sector count (one sector is 128 dwords). The block builds the host-to-device register frame that carries the command. For a write, it then streams the payload out of a user sector buffer as data frames. Every dword it produces goes into a write FIFO, and the link stage behind that FIFO adds CRC, scrambling and primitives.

The block also watches the first dword of each received frame. A DMA Activate frame allows one outgoing data frame, which holds at most 16 sectors. A device-to-host register frame ends the operation and reports the status. For a read, the received data frames go to the read path directly. The sequencer only needs the closing status frame.

The state machine has six states:

- IDLE accepts a request. It goes to WAIT_SECT for a write and to CMD for a read.
- WAIT_SECT holds until a full sector is buffered, then goes to CMD.
- CMD pushes the five command dwords, then goes to WAIT_DEV.
- WAIT_DEV goes back to IDLE on a status frame. During a write that still has data left, it goes to DATA_HDR on a DMA Activate.
- DATA_HDR pushes the data frame header and goes to DATA_BODY.
- DATA_BODY moves payload dwords and goes back to WAIT_DEV when the frame is complete.

Top module: `cmdseq_top`

## Requirements
- R1: After reset the block is idle. op_ready is 1, and wf_valid, ubuf_rd, done and err are 0.
- R2: A write request pushes nothing into the write FIFO until ubuf_sector_ready is 1, meaning at least one complete 512-byte sector is buffered.
- R3: The command frame is five dwords, and wf_last is set on the fifth dword only. The dwords are:
  - dword0 = {8'h00, opcode, 8'h80, 8'h27}
  - dword1 = {8'h40, lba[23:0]}
  - dword2 = {8'h00, lba[47:24]}
  - dword3 = zero-extended sector count
  - dword4 = 0
- R4: The opcode is 8'h25 for a read and 8'h35 for a write. A read pushes its command frame without waiting on the sector buffer.
- R5: Write payload moves only after a received frame whose first dword has bits [7:0] = 8'h39 (DMA Activate). Each data frame starts with the header dword 32'h0000_0046, followed by the payload dwords in buffer order.
- R6: A data frame carries at most 16 sectors (2048 payload dwords). A longer write is split, and every frame after the first needs its own DMA Activate.
- R7: Each sector is started only while ubuf_sector_ready is 1. ubuf_rd is asserted only in a cycle where the dword is accepted (wf_valid=1, wf_full=0). While wf_full is 1, no dword is lost or repeated.
- R8: A received frame whose first dword has bits [7:0] = 8'h34 (device-to-host register frame) ends the operation. In the next cycle done pulses for exactly one cycle and op_ready returns to 1. err pulses together with done when bit 16 of that dword (status bit 0) is set.
- R9: op_valid has no effect while busy. A DMA Activate received during a read has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Request strobe, taken when op_ready is 1 |
| op_write | input | 1 | 1 = write, 0 = read |
| op_lba | input | 48 | Starting logical block address |
| op_count | input | CNT_W | Sector count, nonzero |
| op_ready | output | 1 | Idle and able to take a request |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Device reported an error, valid with done |
| ubuf_sector_ready | input | 1 | Sector buffer holds at least one full sector |
| ubuf_data | input | 32 | Head dword of the sector buffer |
| ubuf_rd | output | 1 | Pop the sector buffer head |
| wf_full | input | 1 | Write FIFO cannot accept a dword |
| wf_valid | output | 1 | Dword offered to the write FIFO |
| wf_data | output | 32 | Dword to the write FIFO |
| wf_last | output | 1 | Last dword of a frame |
| rx_valid | input | 1 | Received dword valid |
| rx_sof | input | 1 | Received dword is the first of a frame |
| rx_data | input | 32 | Received dword |

## Verification
The bench issues a write while the sector buffer is empty. A sequencer that did not gate on a full sector would send the command early.

It sends a 17-sector write. This checks that the 16-sector split happens, and that the remainder waits for a second DMA Activate instead of running on or stopping at 2048 dwords.

It starves the buffer halfway through a data frame while the FIFO toggles full. A design that popped without a push, or started a sector that was not yet present, would show up as reordered or duplicated payload.

Stray DMA Activates during a read and requests made while busy must leave the FIFO untouched. An error status must raise err together with done.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

    localparam logic [7:0] FIS_REG_H2D = 8'h27;
    localparam logic [7:0] FIS_REG_D2H = 8'h34;
    localparam logic [7:0] FIS_DMA_ACT = 8'h39;
    localparam logic [7:0] FIS_DATA    = 8'h46;

    localparam logic [7:0] OPC_READ_EXT  = 8'h25;
    localparam logic [7:0] OPC_WRITE_EXT = 8'h35;

    localparam logic [7:0] H2D_CMD_FLAG  = 8'h80;
    localparam logic [7:0] DEV_LBA_MODE  = 8'h40;
    localparam int         H2D_DWORDS    = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_SECT,
        ST_CMD,
        ST_WAIT_DEV,
        ST_DATA_HDR,
        ST_DATA_BODY
    } seq_state_t;

endpackage

// File: rtl/cmdseq_h2d_fmt.sv
module cmdseq_h2d_fmt
    import cmdseq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [2:0]       idx,
    input  logic             is_write,
    input  logic [47:0]      lba,
    input  logic [CNT_W-1:0] count,
    output logic [31:0]      dword,
    output logic             last
);
    logic [7:0] opcode;

    always_comb begin
        opcode = is_write ? OPC_WRITE_EXT : OPC_READ_EXT;
        unique case (idx)
            3'd0:    dword = {8'h00, opcode, H2D_CMD_FLAG, FIS_REG_H2D};
            3'd1:    dword = {DEV_LBA_MODE, lba[23:0]};
            3'd2:    dword = {8'h00, lba[47:24]};
            3'd3:    dword = 32'(count);
            default: dword = 32'h0;
        endcase
        last = (idx == 3'(H2D_DWORDS - 1));
    end

endmodule

// File: rtl/cmdseq_rx_decode.sv
module cmdseq_rx_decode
    import cmdseq_pkg::*;
(
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic [31:0] rx_data,
    output logic        is_act,
    output logic        is_d2h,
    output logic        d2h_err
);
    logic head;

    always_comb begin
        head    = rx_valid && rx_sof;
        is_act  = head && (rx_data[7:0] == FIS_DMA_ACT);
        is_d2h  = head && (rx_data[7:0] == FIS_REG_D2H);
        d2h_err = rx_data[16];
    end

endmodule

// File: rtl/cmdseq_xfer_cnt.sv
module cmdseq_xfer_cnt #(
    parameter int CNT_W     = 16,
    parameter int SECTOR_DW = 128,
    parameter int MAX_SECT  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] count,
    input  logic             fis_start,
    input  logic             pop,
    output logic             fis_last,
    output logic             rem_zero,
    output logic             sect_start
);
    localparam int OFF_W  = $clog2(SECTOR_DW);
    localparam int REM_W  = CNT_W + OFF_W;
    localparam int MAX_DW = MAX_SECT * SECTOR_DW;
    localparam int FIS_W  = $clog2(MAX_DW) + 1;

    logic [REM_W-1:0] rem_dw;
    logic [FIS_W-1:0] fis_left;
    logic [OFF_W-1:0] sect_off;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_dw   <= '0;
            fis_left <= '0;
            sect_off <= '0;
        end else begin
            if (load) begin
                rem_dw   <= {count, {OFF_W{1'b0}}};
                sect_off <= '0;
            end else if (pop) begin
                rem_dw   <= rem_dw - 1'b1;
                sect_off <= sect_off + 1'b1;
            end
            if (fis_start) begin
                fis_left <= (rem_dw > REM_W'(MAX_DW)) ? FIS_W'(MAX_DW)
                                                      : rem_dw[FIS_W-1:0];
            end else if (pop) begin
                fis_left <= fis_left - 1'b1;
            end
        end
    end

    assign fis_last   = (fis_left == FIS_W'(1));
    assign rem_zero   = (rem_dw == '0);
    assign sect_start = (sect_off == '0);

endmodule

// File: rtl/cmdseq_top.sv
module cmdseq_top
    import cmdseq_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SECTOR_DW = 128,
    parameter int MAX_SECT  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic             op_write,
    input  logic [47:0]      op_lba,
    input  logic [CNT_W-1:0] op_count,
    output logic             op_ready,
    output logic             busy,
    output logic             done,
    output logic             err,
    input  logic             ubuf_sector_ready,
    input  logic [31:0]      ubuf_data,
    output logic             ubuf_rd,
    input  logic             wf_full,
    output logic             wf_valid,
    output logic [31:0]      wf_data,
    output logic             wf_last,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic [31:0]      rx_data
);
    seq_state_t       st_q, st_d;
    logic [2:0]       idx_q;
    logic             wr_q;
    logic [47:0]      lba_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q, err_q;

    logic [31:0] cmd_dw;
    logic        cmd_last;
    logic        rx_act, rx_d2h, rx_err;
    logic        fis_last, rem_zero, sect_start;
    logic        accept, fis_start, can_pop;

    cmdseq_h2d_fmt #(.CNT_W(CNT_W)) u_fmt (
        .idx      (idx_q),
        .is_write (wr_q),
        .lba      (lba_q),
        .count    (cnt_q),
        .dword    (cmd_dw),
        .last     (cmd_last)
    );

    cmdseq_rx_decode u_rx (
        .rx_valid (rx_valid),
        .rx_sof   (rx_sof),
        .rx_data  (rx_data),
        .is_act   (rx_act),
        .is_d2h   (rx_d2h),
        .d2h_err  (rx_err)
    );

    cmdseq_xfer_cnt #(
        .CNT_W     (CNT_W),
        .SECTOR_DW (SECTOR_DW),
        .MAX_SECT  (MAX_SECT)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .count      (op_count),
        .fis_start  (fis_start),
        .pop        (ubuf_rd),
        .fis_last   (fis_last),
        .rem_zero   (rem_zero),
        .sect_start (sect_start)
    );

    assign accept    = (st_q == ST_IDLE) && op_valid;
    assign fis_start = (st_q == ST_WAIT_DEV) && (st_d == ST_DATA_HDR);
    assign can_pop   = sect_start ? ubuf_sector_ready : 1'b1;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (op_valid) st_d = op_write ? ST_WAIT_SECT : ST_CMD;
            end
            ST_WAIT_SECT: begin
                if (ubuf_sector_ready) st_d = ST_CMD;
            end
            ST_CMD: begin
                if (!wf_full && cmd_last) st_d = ST_WAIT_DEV;
            end
            ST_WAIT_DEV: begin
                if (rx_d2h) st_d = ST_IDLE;
                else if (rx_act && wr_q && !rem_zero) st_d = ST_DATA_HDR;
            end
            ST_DATA_HDR: begin
                if (!wf_full) st_d = ST_DATA_BODY;
            end
            ST_DATA_BODY: begin
                if (ubuf_rd && fis_last) st_d = ST_WAIT_DEV;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wf_valid = 1'b0;
        wf_data  = 32'h0;
        wf_last  = 1'b0;
        ubuf_rd  = 1'b0;
        unique case (st_q)
            ST_CMD: begin
                wf_valid = 1'b1;
                wf_data  = cmd_dw;
                wf_last  = cmd_last;
            end
            ST_DATA_HDR: begin
                wf_valid = 1'b1;
                wf_data  = {24'h0, FIS_DATA};
            end
            ST_DATA_BODY: begin
                wf_valid = can_pop;
                wf_data  = ubuf_data;
                wf_last  = fis_last;
                ubuf_rd  = can_pop && !wf_full;
            end
            default: ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            wr_q   <= 1'b0;
            lba_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                wr_q  <= op_write;
                lba_q <= op_lba;
                cnt_q <= op_count;
                idx_q <= '0;
            end else if (st_q == ST_CMD && !wf_full) begin
                idx_q <= idx_q + 1'b1;
            end
            done_q <= (st_q == ST_WAIT_DEV) && rx_d2h;
            err_q  <= (st_q == ST_WAIT_DEV) && rx_d2h && rx_err;
        end
    end

    assign op_ready = (st_q == ST_IDLE);
    assign busy     = (st_q != ST_IDLE);
    assign done     = done_q;
    assign err      = err_q;

endmodule

// File: rtl/cmdseq_chk.sv
module cmdseq_chk #(
    parameter int SECTOR_DW = 128,
    parameter int MAX_SECT  = 16
) (
    input logic clk,
    input logic rst_n,
    input logic op_ready,
    input logic done,
    input logic err,
    input logic ubuf_rd,
    input logic ubuf_sector_ready,
    input logic wf_valid,
    input logic wf_full,
    input logic wf_last
);
    localparam int OFF_W  = $clog2(SECTOR_DW);
    localparam int MAX_DW = MAX_SECT * SECTOR_DW;
    localparam int RUN_W  = $clog2(MAX_DW + 2) + 1;

    logic [OFF_W-1:0] pop_off;
    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pop_off <= '0;
            run_len <= '0;
        end else begin
            if (ubuf_rd) pop_off <= pop_off + 1'b1;
            if (wf_valid && !wf_full) run_len <= wf_last ? '0 : run_len + 1'b1;
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        op_ready |-> (!wf_valid && !ubuf_rd));

    a_r7_pop_with_push: assert property (@(posedge clk) disable iff (!rst_n)
        ubuf_rd |-> (wf_valid && !wf_full));

    a_r7_sector_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (ubuf_rd && pop_off == '0) |-> ubuf_sector_ready);

    a_r6_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
        (wf_valid && !wf_full) |-> (run_len <= RUN_W'(MAX_DW)));

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> op_ready);

    a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind cmdseq_top cmdseq_chk #(
    .SECTOR_DW (SECTOR_DW),
    .MAX_SECT  (MAX_SECT)
) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .op_ready          (op_ready),
    .done              (done),
    .err               (err),
    .ubuf_rd           (ubuf_rd),
    .ubuf_sector_ready (ubuf_sector_ready),
    .wf_valid          (wf_valid),
    .wf_full           (wf_full),
    .wf_last           (wf_last)
);

// File: tb/tb_cmdseq_top.sv
module tb_cmdseq_top;
    localparam int SDW = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_write = 1'b0;
    logic [47:0] op_lba = '0;
    logic [15:0] op_count = '0;
    logic        op_ready, busy, done, err;
    logic        ubuf_sector_ready;
    logic [31:0] ubuf_data;
    logic        ubuf_rd;
    logic        wf_full = 1'b0;
    logic        wf_valid, wf_last;
    logic [31:0] wf_data;
    logic        rx_valid = 1'b0, rx_sof = 1'b0;
    logic [31:0] rx_data = '0;

    int ub_words = 0;
    int pop_idx = 0;
    int ncap = 0;
    int ndone = 0;
    int nerr = 0;
    int checks = 0;
    int errors = 0;
    logic stall_en = 1'b0;
    logic [31:0] cap_d [0:16383];
    logic        cap_l [0:16383];

    assign ubuf_sector_ready = (ub_words >= SDW);
    assign ubuf_data = pop_idx;

    cmdseq_top dut (.*);

    always #10 clk = ~clk;

    always @(negedge clk) wf_full <= stall_en ? ~wf_full : 1'b0;

    // monitor: samples 2 ns before the rising edge, applies pops after it
    always begin
        logic pend;
        @(negedge clk);
        #8;
        pend = 1'b0;
        if (rst_n) begin
            if (wf_valid && !wf_full) begin
                cap_d[ncap] = wf_data;
                cap_l[ncap] = wf_last;
                ncap++;
            end
            pend = ubuf_rd;
            if (done) ndone++;
            if (err) nerr++;
        end
        @(posedge clk);
        #1;
        if (pend) begin
            ub_words--;
            pop_idx++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic start_op(input logic wr, input logic [47:0] lba, input logic [15:0] cnt);
        @(negedge clk);
        op_valid = 1'b1; op_write = wr; op_lba = lba; op_count = cnt;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic send_rx(input logic [31:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_sof = 1'b1; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_data = '0;
    endtask

    task automatic wait_caps(input int n);
        for (int i = 0; i < 20000 && ncap < n; i++) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_h2d(input string tag, input int b, input logic [7:0] opc,
                           input logic [47:0] lba, input logic [15:0] cnt);
        chk({tag, " R3 dw0"}, cap_d[b],   {8'h00, opc, 8'h80, 8'h27});
        chk({tag, " R3 dw1"}, cap_d[b+1], {8'h40, lba[23:0]});
        chk({tag, " R3 dw2"}, cap_d[b+2], {8'h00, lba[47:24]});
        chk({tag, " R3 dw3"}, cap_d[b+3], {16'h0, cnt});
        chk({tag, " R3 dw4"}, cap_d[b+4], 32'h0);
        chk({tag, " R3 last"}, {28'h0, cap_l[b], cap_l[b+1], cap_l[b+2], cap_l[b+4]}, 32'h1);
    endtask

    task automatic chk_payload(input string tag, input int b, input int n, input int first);
        int bad = 0;
        for (int i = 0; i < n; i++) if (cap_d[b+i] !== 32'(first + i)) bad++;
        chk(tag, bad, 0);
    endtask

    task automatic t_reset();
        chk("R1 op_ready", op_ready, 1);
        chk("R1 wf_valid", wf_valid, 0);
        chk("R1 ubuf_rd", ubuf_rd, 0);
        chk("R1 done/err", {done, err}, 0);
    endtask

    task automatic t_write_one();
        int b = ncap;
        int p0 = pop_idx;
        int d0 = ndone;
        start_op(1'b1, 48'hA1B2_C3D4_E5F6, 16'd1);
        idle(20);
        chk("R2 no push before sector", ncap - b, 0);
        ub_words += SDW;
        wait_caps(b + 5);
        idle(10);
        chk("R4 write cmd only, no data before activate R5", ncap - b, 5);
        chk_h2d("write", b, 8'h35, 48'hA1B2_C3D4_E5F6, 16'd1);
        start_op(1'b0, 48'h0, 16'd9); // R9 request while busy
        send_rx(32'h0000_0039);
        wait_caps(b + 5 + 1 + SDW);
        idle(10);
        chk("R5 header", cap_d[b+5], 32'h0000_0046);
        chk("R5 frame size", ncap - b, 5 + 1 + SDW);
        chk("R5 last on final payload", {cap_l[b+5], cap_l[b+5+SDW]}, 2'b01);
        chk_payload("R5 payload order", b + 6, SDW, p0);
        send_rx(32'h0050_0034);
        idle(3);
        chk("R8 done pulse", ndone - d0, 1);
        chk("R8 ready after done", op_ready, 1);
        idle(10);
        chk("R9 busy request ignored", ncap - b, 5 + 1 + SDW);
    endtask

    task automatic t_read();
        int b = ncap;
        int d0 = ndone;
        int e0 = nerr;
        start_op(1'b0, 48'h1234_5678_9ABC, 16'd3);
        wait_caps(b + 5);
        idle(5);
        chk("R4 read cmd without buffer", ncap - b, 5);
        chk_h2d("read", b, 8'h25, 48'h1234_5678_9ABC, 16'd3);
        send_rx(32'h0000_0039);
        idle(10);
        chk("R9 activate ignored on read", ncap - b, 5);
        chk("R9 still busy", busy, 1);
        send_rx(32'h0051_0034);
        idle(3);
        chk("R8 done with error", ndone - d0, 1);
        chk("R8 err pulse", nerr - e0, 1);
    endtask

    task automatic t_split();
        int b = ncap;
        int p0 = pop_idx;
        int nl = 0;
        ub_words += 17 * SDW;
        start_op(1'b1, 48'h10, 16'd17);
        wait_caps(b + 5);
        send_rx(32'h0000_0039);
        wait_caps(b + 5 + 1 + 2048);
        idle(20);
        chk("R6 first frame stops at 16 sectors", ncap - b, 5 + 1 + 2048);
        send_rx(32'h0000_0039);
        wait_caps(b + 5 + 2 + 2048 + SDW);
        idle(10);
        chk("R6 total dwords", ncap - b, 5 + 2 + 2048 + SDW);
        chk("R6 second header", cap_d[b+5+1+2048], 32'h0000_0046);
        for (int i = b; i < ncap; i++) if (cap_l[i]) nl++;
        chk("R6 frame count", nl, 3);
        chk("R6 last positions", {cap_l[b+4], cap_l[b+5+2048], cap_l[ncap-1]}, 3'b111);
        chk_payload("R6 payload first", b + 6, 2048, p0);
        chk_payload("R6 payload second", b + 7 + 2048, SDW, p0 + 2048);
        send_rx(32'h0050_0034);
        idle(3);
        chk("R8 ready after split", op_ready, 1);
    endtask

    task automatic t_stall_gate();
        int b = ncap;
        int p0 = pop_idx;
        int e0 = nerr;
        ub_words += SDW;
        stall_en = 1'b1;
        start_op(1'b1, 48'h77, 16'd2);
        wait_caps(b + 5);
        send_rx(32'h0000_0039);
        wait_caps(b + 6 + SDW);
        idle(40);
        chk("R7 second sector waits for buffer", ncap - b, 6 + SDW);
        ub_words += SDW;
        wait_caps(b + 6 + 2 * SDW);
        idle(10);
        chk("R7 frame complete under stall", ncap - b, 6 + 2 * SDW);
        chk_payload("R7 payload order under stall", b + 6, 2 * SDW, p0);
        stall_en = 1'b0;
        send_rx(32'h0050_0034);
        idle(3);
        chk("R8 no err on clean status", nerr - e0, 0);
        chk("R8 idle", op_ready, 1);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog act=%0d exp=0", checks);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        #5 rst_n = 1'b1;
        idle(2);
        t_reset();
        t_write_one();
        t_read();
        t_split();
        t_stall_gate();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule